// File: doc/BRIEF.md
# Interrupt Status Latch with Set/Clear Registers

This unit keeps the pending-interrupt state for one host channel. It latches two event sources: a device interrupt (bit 0) and a memory/bus error (bit 1). Software reads the pending bits from a status register. It can force bits on through a set register and drop them through a write-one-to-clear register. Each of these three registers has its own word address. The unit drives a registered, level-type interrupt output that stays high while either bit is pending.

When a bus error arrives while the error bit is clear, the unit also captures the failing 64-bit address. Software reads that address as a low word and a high word. The captured value stays frozen until software clears the error bit, so the first failure of a burst is the one reported. Reads are registered: read data appears one cycle after the word address is presented.

Top module: `irq_status_unit`

## Requirements
- R1: While and after a synchronous active-high reset, both pending bits and the captured address are zero, and both `irq_out` and `rdata` are zero.
- R2: Presenting word address 3 returns the status in `rdata` one cycle later: bit 0 is the device interrupt, bit 1 is the bus error, and all other bits are zero.
- R3: A cycle with `dev_evt` or `err_evt` high sets the matching pending bit. The bit then stays set until it is cleared.
- R4: A write to word address 5 sets every pending bit whose `wdata` bit (bit 0 or 1) is 1. A value of 0x3 sets both bits.
- R5: A write to word address 7 clears every pending bit whose `wdata` bit is 1 and leaves the other bit unchanged. A value of 0x3 clears both bits.
- R6: If a source event arrives in the same cycle as a clear write for that bit, the bit stays set.
- R7: On `err_evt` while bit 1 is clear, `err_addr` is captured. Later errors do not change the capture while bit 1 stays set, and setting bit 1 through the set register does not capture. The low word reads at word address 0 and the high word at word address 1.
- R8: `irq_out` is a register that equals the OR of the two pending bits as they stood one cycle earlier.
- R9: Writes to any word address other than 5 and 7 leave the pending bits and the capture unchanged. Reads of unmapped word addresses, including 5 and 7, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |
| dev_evt | input | 1 | Device interrupt event |
| err_evt | input | 1 | Memory/bus error event |
| err_addr | input | 64 | Failing address that accompanies `err_evt` |
| irq_out | output | 1 | Registered level interrupt |

## Verification
Directed sequences separate the three ways a bit can change: by event, by the set register, and by the clear register. Masks 0x1, 0x2 and 0x3 show that each bit is handled on its own. Event-plus-clear collisions distinguish event priority from clear priority. Repeated errors, with and without a clear in between, plus a set-register write of bit 1, show whether the address capture is first-error-only and free of side effects from software. A long stream of random writes, addresses and events is then compared every cycle against a behavioural model, which exposes cross-effects between sources and register accesses that directed cases miss.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned NSRC        = 2;
  localparam int unsigned SRC_DEV     = 0;
  localparam int unsigned SRC_ERR     = 1;
  localparam int unsigned WOFS_ERR_LO = 0;
  localparam int unsigned WOFS_ERR_HI = 1;
  localparam int unsigned WOFS_STAT   = 3;
  localparam int unsigned WOFS_SET    = 5;
  localparam int unsigned WOFS_CLR    = 7;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_ERR_LO,
    RSEL_ERR_HI,
    RSEL_STAT
  } rsel_e;
endpackage

// File: rtl/isu_decode.sv
module isu_decode
  import isu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   set_mask,
  output logic [NSRC-1:0]   clr_mask,
  output rsel_e             rsel
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(WOFS_ERR_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(WOFS_ERR_HI);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WOFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(WOFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(WOFS_CLR);

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (wr_en && addr == A_SET) set_mask = wdata[NSRC-1:0];
    if (wr_en && addr == A_CLR) clr_mask = wdata[NSRC-1:0];
  end

  always_comb begin
    unique case (addr)
      A_LO:    rsel = RSEL_ERR_LO;
      A_HI:    rsel = RSEL_ERR_HI;
      A_STAT:  rsel = RSEL_STAT;
      default: rsel = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/isu_bit.sv
module isu_bit (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (evt | set) q <= 1'b1;
    else if (clr)       q <= 1'b0;
  end

  // R4
  set_load_chk: assert property (@(posedge clk) disable iff (rst) set |=> q);
  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst) (evt && clr) |=> q);
  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst) (q && !clr) |=> q);
  // R5
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst) (clr && !evt && !set) |=> !q);
endmodule

// File: rtl/isu_errcap.sv
module isu_errcap #(
  parameter int unsigned EADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_evt,
  input  logic               err_pend,
  input  logic [EADDR_W-1:0] addr_in,
  output logic [EADDR_W-1:0] addr_q
);
  logic take;
  assign take = err_evt & ~err_pend;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (take) addr_q <= addr_in;
  end

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_pend |=> $stable(addr_q));
  // R7
  cap_first_chk: assert property (@(posedge clk) disable iff (rst)
    (err_evt && !err_pend) |=> (addr_q == $past(addr_in)));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                dev_evt,
  input  logic                err_evt,
  input  logic [2*DATA_W-1:0] err_addr,
  output logic                irq_out
);
  localparam int unsigned EADDR_W = 2 * DATA_W;

  logic [NSRC-1:0]    set_mask, clr_mask, evt_vec, pend;
  logic [EADDR_W-1:0] cap_addr;
  rsel_e              rsel;

  assign evt_vec[SRC_DEV] = dev_evt;
  assign evt_vec[SRC_ERR] = err_evt;

  isu_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .set_mask(set_mask), .clr_mask(clr_mask), .rsel(rsel)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    isu_bit u_bit (
      .clk(clk), .rst(rst), .evt(evt_vec[g]),
      .set(set_mask[g]), .clr(clr_mask[g]), .q(pend[g])
    );
  end

  isu_errcap #(.EADDR_W(EADDR_W)) u_errcap (
    .clk(clk), .rst(rst), .err_evt(err_evt), .err_pend(pend[SRC_ERR]),
    .addr_in(err_addr), .addr_q(cap_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      irq_out <= |pend;
      unique case (rsel)
        RSEL_ERR_LO: rdata <= cap_addr[DATA_W-1:0];
        RSEL_ERR_HI: rdata <= cap_addr[EADDR_W-1:DATA_W];
        RSEL_STAT:   rdata <= DATA_W'(pend);
        default:     rdata <= '0;
      endcase
    end
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst) (|pend) |=> irq_out);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst) !(|pend) |=> !irq_out);
  // R2
  stat_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel == RSEL_STAT) |=> (rdata[DATA_W-1:NSRC] == '0));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dev_evt = 1'b0;
  logic        err_evt = 1'b0;
  logic [63:0] err_addr = '0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [1:0]  m_stat = '0;
  logic [63:0] m_cap  = '0;
  logic        m_irq  = 1'b0;
  logic [31:0] m_rd   = '0;

  always #5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dev_evt(dev_evt), .err_evt(err_evt),
    .err_addr(err_addr), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model the edge, then compare at 1 ns past it
  task automatic cyc();
    logic [31:0] nrd;
    logic [1:0]  setm, clrm, ev;
    string       rtag;
    case (addr)
      4'd0:    begin nrd = m_cap[31:0];        rtag = "R7 lo word"; end
      4'd1:    begin nrd = m_cap[63:32];       rtag = "R7 hi word"; end
      4'd3:    begin nrd = {30'b0, m_stat};    rtag = "R2 status";  end
      default: begin nrd = '0;                 rtag = "R9 unmapped"; end
    endcase
    setm = (wr_en && addr == 4'd5) ? wdata[1:0] : 2'b00;
    clrm = (wr_en && addr == 4'd7) ? wdata[1:0] : 2'b00;
    ev   = {err_evt, dev_evt};
    @(posedge clk);
    m_irq = |m_stat;
    m_rd  = nrd;
    if (err_evt && !m_stat[1]) m_cap = err_addr;
    m_stat = ev | setm | (m_stat & ~clrm);
    #1;
    chk(rtag, rdata, m_rd);
    chk("R8 irq", irq_out, m_irq);
    wr_en = 0; dev_evt = 0; err_evt = 0; addr = 4'd2; wdata = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [31:0] exp);
    addr = a; cyc();
    chk(tag, rdata, exp);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", irq_out, 0);
    rst = 0;
    rd("R1 status", 4'd3, 0);
    rd("R1 cap lo", 4'd0, 0);

    // R4 set register
    wr(4'd5, 32'h3);
    rd("R4 set both", 4'd3, 3);
    chk("R8 irq high", irq_out, 1);
    // R5 clear register, bit by bit
    wr(4'd7, 32'h1);
    rd("R5 clear bit0", 4'd3, 2);
    wr(4'd7, 32'h2);
    rd("R5 clear bit1", 4'd3, 0);
    rd("R8 irq low", 4'd3, 0);
    chk("R8 irq low", irq_out, 0);
    wr(4'd5, 32'h3);
    wr(4'd7, 32'h3);
    rd("R5 clear both", 4'd3, 0);

    // R3 event latch
    dev_evt = 1; cyc();
    repeat (3) cyc();
    rd("R3 dev held", 4'd3, 1);

    // R6 event beats clear
    dev_evt = 1; wr(4'd7, 32'h1);
    rd("R6 event wins", 4'd3, 1);
    wr(4'd7, 32'h1);
    rd("R5 cleared", 4'd3, 0);

    // R7 first-error capture
    err_evt = 1; err_addr = 64'h1234_5678_9abc_def0; cyc();
    rd("R7 lo", 4'd0, 32'h9abc_def0);
    rd("R7 hi", 4'd1, 32'h1234_5678);
    err_evt = 1; err_addr = 64'hffff_0000_ffff_0000; cyc();
    rd("R7 held lo", 4'd0, 32'h9abc_def0);
    rd("R3 err set", 4'd3, 2);
    wr(4'd7, 32'h2);
    err_evt = 1; err_addr = 64'h0000_00aa_0000_00bb; cyc();
    rd("R7 recapture hi", 4'd1, 32'h0000_00aa);
    wr(4'd7, 32'h2);
    wr(4'd5, 32'h2);
    rd("R7 set no capture", 4'd0, 32'h0000_00bb);
    wr(4'd7, 32'h3);

    // R9 writes elsewhere ignored, unmapped reads zero
    wr(4'd5, 32'h1);
    for (int a = 0; a < 16; a++)
      if (a != 5 && a != 7) wr(4'(a), 32'hffff_ffff);
    rd("R9 status kept", 4'd3, 1);
    rd("R9 cap kept", 4'd1, 32'h0000_00aa);
    rd("R9 read 5", 4'd5, 0);
    rd("R9 read 7", 4'd7, 0);
    rd("R9 read 6", 4'd6, 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      wr_en    = ($urandom % 4) == 0;
      addr     = 4'($urandom % 9);
      wdata    = $urandom;
      dev_evt  = ($urandom % 6) == 0;
      err_evt  = ($urandom % 8) == 0;
      err_addr = {$urandom, $urandom};
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule